// File: doc/BRIEF.md
# Multiblock Token Readout Controller

This block runs on each data board in a crate. It lets one long host block read drain several boards as if they were a single source. Every board decodes a common address window, and only the board that currently holds a token answers reads there. The token travels along a private daisy-chain line. A board that is not at the end of the chain sends it on once it has delivered the data of a programmed number of events. The board at the end of the chain keeps the token and ends the host transfer with a bus error once its own block is exhausted. The first board of the chain watches the bus-error line and takes the token back, so the next round starts from the left.

The same block covers a board working alone. Reads to its private data window are answered until the programmed block has gone out. If bus-error termination is enabled, a read after that point gets a bus error instead, and a sticky status bit records that the error came from the board on purpose. The block also counts events that have been stored and raises a level flag when a full block is waiting. It sends a single interrupt pulse, which must be re-armed by a special write to the private window.

Top module: `mblk_rd_ctrl`

## Requirements
- R1: A read in the shared window is answered (`resp_en`=1) only when multiblock is enabled, the token is held and `win_lo <= addr < win_hi`. A read whose upper address bits `addr[AW-1:OB]` equal `cfg_own_page` is answered whenever the private window is enabled and the block is not finished.
- R2: On the first clock edge after reset is released, a board configured as first with multiblock enabled takes the token. Any other board starts without it.
- R3: A board that is not last, holds the token, and has a read answered with `evt_last`=1 for the quota-th event drops the token at that edge. It drives `tok_out` high for exactly the following cycle. A quota of 0 acts as 1.
- R4: `tok_in`=1 gives the board the token at that clock edge. The board does not hold the token during the cycle in which `tok_in` is first seen.
- R5: A board configured as last keeps the token when its quota is reached. With bus-error response enabled, later reads in the shared window get `berr_out`=1 and `resp_en`=0.
- R6: With multiblock disabled and the quota reached, a read in the private window gets `berr_out`=1 if bus-error response is enabled. If it is disabled, the read gets neither a bus error nor data.
- R7: When `berr_in` is seen, a board configured as first with multiblock enabled takes the token. Every board clears its event progress, so reads are answered again.
- R8: `st_berr` goes high at the edge where the board drives `berr_out`. It stays high until a cycle with `stat_rd`=1, or until reset.
- R9: `st_level` is high while the count of stored, unsent events is at least the quota (a quota of 0 acts as 1). A stored event adds one, and an answered read with `evt_last`=1 removes one.
- R10: `irq` is a one-cycle pulse. It is raised one cycle after the level flag is seen while the board is armed, interrupts are enabled, and the board is either alone or configured as first. Raising it disarms the board.
- R11: A write of exactly 0x80000000 to the private window re-arms the interrupt. A write of any other value leaves the board disarmed.
- R12: While reset is asserted, and right after it, `tok_out`, `irq`, `st_tok`, `st_berr` and `st_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mb_en | input | 1 | Take part in the shared-window token chain |
| cfg_first | input | 1 | Board is first in the chain |
| cfg_last | input | 1 | Board is last in the chain |
| cfg_berr_en | input | 1 | Allow bus-error termination |
| cfg_irq_en | input | 1 | Allow the event-level interrupt |
| cfg_own_en | input | 1 | Enable the private data window |
| cfg_own_page | input | AW-OB | Upper address bits of the private window |
| cfg_win_lo | input | AW | Shared window lower bound (inclusive) |
| cfg_win_hi | input | AW | Shared window upper bound (exclusive) |
| cfg_quota | input | CW | Events per block |
| bus_addr | input | AW | Host cycle address |
| bus_rd | input | 1 | Host read in this cycle |
| bus_wr | input | 1 | Host write in this cycle |
| bus_wdata | input | DW | Host write data |
| evt_stored | input | 1 | One event fully stored in the buffer |
| evt_last | input | 1 | The word being read closes an event |
| tok_in | input | 1 | Token from the previous board |
| berr_in | input | 1 | Monitored bus-error line |
| stat_rd | input | 1 | Host read of the status register |
| resp_en | output | 1 | Answer this read with data |
| berr_out | output | 1 | Answer this read with a bus error |
| tok_out | output | 1 | Token pulse to the next board |
| irq | output | 1 | Event-level interrupt pulse |
| st_tok | output | 1 | Token held |
| st_berr | output | 1 | Deliberate bus error occurred |
| st_level | output | 1 | A full block is waiting |

## Verification
The address decode is swept with a table of addresses just below, at, and just above both edges of the shared window, plus hits and misses on the private page. This shows whether the bounds are inclusive or exclusive and whether the two windows are kept apart. The chain roles (first only, middle, first-and-last, alone) are each run through a full block. This shows token hand-off apart from termination, and reclaim by the first board apart from a board that simply ignores `berr_in`. The interrupt path is driven with a correct re-arm word, a word that is off by one bit, and a board in the middle of the chain. This tells arming apart from the level condition and from the permission that comes with the role.

// File: rtl/mbrd_pkg.sv
package mbrd_pkg;

    // Word that re-arms the event-level interrupt when written to the private window
    localparam logic [31:0] REARM_WORD = 32'h8000_0000;

    // Control flags of the token and quota engine
    typedef struct packed {
        logic started;    // first edge after reset has passed
        logic tok;        // token held
        logic tok_pulse;  // token hand-off pulse to the next board
        logic blk_done;   // quota of events delivered in this round
        logic berr_flag;  // sticky deliberate bus-error status
    } tok_ctl_t;

    // Control flags of the interrupt engine
    typedef struct packed {
        logic armed;
        logic irq;
    } irq_ctl_t;

endpackage

// File: rtl/mbrd_decode.sv
module mbrd_decode #(
    parameter int AW = 24,
    parameter int OB = 8
) (
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    win_lo,
    input  logic [AW-1:0]    win_hi,
    input  logic [AW-OB-1:0] own_page,
    input  logic             mb_en,
    input  logic             own_en,
    input  logic             tok,
    output logic             sel_mb,
    output logic             sel_own
);
    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr >= win_lo);
        below_hi = (addr < win_hi);
        sel_mb   = mb_en & tok & above_lo & below_hi;
        sel_own  = own_en & (addr[AW-1:OB] == own_page);
    end
endmodule

// File: rtl/mbrd_token.sv
module mbrd_token
    import mbrd_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mb_en,
    input  logic          first,
    input  logic          last,
    input  logic          berr_en,
    input  logic [CW-1:0] quota,
    input  logic          rd,
    input  logic          sel_mb,
    input  logic          sel_own,
    input  logic          evt_last,
    input  logic          tok_in,
    input  logic          berr_in,
    input  logic          stat_rd,
    output logic          resp_en,
    output logic          berr_out,
    output logic          evt_sent,
    output logic          tok_held,
    output logic          tok_out,
    output logic          berr_flag
);
    typedef struct packed {
        tok_ctl_t      ctl;
        logic [CW-1:0] cnt;
    } tok_st_t;

    localparam tok_st_t RST_ST = '0;

    tok_st_t     st_q, st_d;
    logic        hit;
    logic        term_ok;
    logic [CW:0] cnt_inc;
    logic        quota_hit;

    always_comb begin
        hit       = sel_mb | sel_own;
        resp_en   = rd & hit & ~st_q.ctl.blk_done;
        term_ok   = berr_en & st_q.ctl.blk_done &
                    ((sel_own & ~mb_en) | (sel_mb & last));
        berr_out  = rd & term_ok;
        evt_sent  = resp_en & evt_last;
        cnt_inc   = {1'b0, st_q.cnt} + 1'b1;
        quota_hit = (cnt_inc >= {1'b0, quota});

        st_d = st_q;
        st_d.ctl.started   = 1'b1;
        st_d.ctl.tok_pulse = 1'b0;

        if (!st_q.ctl.started) begin
            st_d.ctl.tok = mb_en & first;
        end
        if (tok_in) begin
            st_d.ctl.tok = 1'b1;
        end

        if (evt_sent) begin
            st_d.cnt = cnt_inc[CW-1:0];
            if (quota_hit) begin
                if (mb_en & st_q.ctl.tok & ~last) begin
                    st_d.ctl.tok       = 1'b0;
                    st_d.ctl.tok_pulse = 1'b1;
                    st_d.cnt           = '0;
                end else begin
                    st_d.ctl.blk_done = 1'b1;
                end
            end
        end

        if (berr_in) begin
            st_d.cnt          = '0;
            st_d.ctl.blk_done = 1'b0;
            if (mb_en & first) begin
                st_d.ctl.tok = 1'b1;
            end
        end

        if (stat_rd) begin
            st_d.ctl.berr_flag = 1'b0;
        end
        if (berr_out) begin
            st_d.ctl.berr_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tok_held  = st_q.ctl.tok;
    assign tok_out   = st_q.ctl.tok_pulse;
    assign berr_flag = st_q.ctl.berr_flag;
endmodule

// File: rtl/mbrd_level.sv
module mbrd_level
    import mbrd_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] quota,
    input  logic          evt_stored,
    input  logic          evt_sent,
    input  logic          irq_en,
    input  logic          mb_en,
    input  logic          first,
    input  logic          rearm,
    output logic          level,
    output logic          irq
);
    typedef struct packed {
        irq_ctl_t      ctl;
        logic [CW-1:0] stored;
    } lvl_st_t;

    localparam lvl_st_t       RST_ST = '{ctl: '{armed: 1'b1, irq: 1'b0}, stored: '0};
    localparam logic [CW-1:0] ONE    = CW'(1);

    lvl_st_t       st_q, st_d;
    logic [CW-1:0] eff_quota;
    logic          allow;
    logic          fire;

    always_comb begin
        eff_quota = (quota == '0) ? ONE : quota;
        level     = (st_q.stored >= eff_quota);
        allow     = ~mb_en | first;
        fire      = st_q.ctl.armed & level & irq_en & allow;

        st_d = st_q;
        if (evt_stored & ~evt_sent & (st_q.stored != '1)) begin
            st_d.stored = st_q.stored + ONE;
        end else if (evt_sent & ~evt_stored & (st_q.stored != '0)) begin
            st_d.stored = st_q.stored - ONE;
        end

        st_d.ctl.irq = fire;
        if (rearm) begin
            st_d.ctl.armed = 1'b1;
        end
        if (fire) begin
            st_d.ctl.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.ctl.irq;
endmodule

// File: rtl/mblk_rd_ctrl.sv
module mblk_rd_ctrl
    import mbrd_pkg::*;
#(
    parameter int AW = 24,
    parameter int OB = 8,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mb_en,
    input  logic             cfg_first,
    input  logic             cfg_last,
    input  logic             cfg_berr_en,
    input  logic             cfg_irq_en,
    input  logic             cfg_own_en,
    input  logic [AW-OB-1:0] cfg_own_page,
    input  logic [AW-1:0]    cfg_win_lo,
    input  logic [AW-1:0]    cfg_win_hi,
    input  logic [CW-1:0]    cfg_quota,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             evt_stored,
    input  logic             evt_last,
    input  logic             tok_in,
    input  logic             berr_in,
    input  logic             stat_rd,
    output logic             resp_en,
    output logic             berr_out,
    output logic             tok_out,
    output logic             irq,
    output logic             st_tok,
    output logic             st_berr,
    output logic             st_level
);
    localparam logic [DW-1:0] REARM = DW'(REARM_WORD);

    logic sel_mb;
    logic sel_own;
    logic evt_sent;
    logic rearm;

    mbrd_decode #(.AW(AW), .OB(OB)) u_dec (
        .addr     (bus_addr),
        .win_lo   (cfg_win_lo),
        .win_hi   (cfg_win_hi),
        .own_page (cfg_own_page),
        .mb_en    (cfg_mb_en),
        .own_en   (cfg_own_en),
        .tok      (st_tok),
        .sel_mb   (sel_mb),
        .sel_own  (sel_own)
    );

    mbrd_token #(.CW(CW)) u_tok (
        .clk       (clk),
        .rst_n     (rst_n),
        .mb_en     (cfg_mb_en),
        .first     (cfg_first),
        .last      (cfg_last),
        .berr_en   (cfg_berr_en),
        .quota     (cfg_quota),
        .rd        (bus_rd),
        .sel_mb    (sel_mb),
        .sel_own   (sel_own),
        .evt_last  (evt_last),
        .tok_in    (tok_in),
        .berr_in   (berr_in),
        .stat_rd   (stat_rd),
        .resp_en   (resp_en),
        .berr_out  (berr_out),
        .evt_sent  (evt_sent),
        .tok_held  (st_tok),
        .tok_out   (tok_out),
        .berr_flag (st_berr)
    );

    assign rearm = bus_wr & sel_own & (bus_wdata == REARM);

    mbrd_level #(.CW(CW)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .quota      (cfg_quota),
        .evt_stored (evt_stored),
        .evt_sent   (evt_sent),
        .irq_en     (cfg_irq_en),
        .mb_en      (cfg_mb_en),
        .first      (cfg_first),
        .rearm      (rearm),
        .level      (st_level),
        .irq        (irq)
    );
endmodule

// File: rtl/mblk_rd_ctrl_chk.sv
module mblk_rd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_mb_en,
    input logic cfg_first,
    input logic bus_rd,
    input logic tok_in,
    input logic berr_in,
    input logic resp_en,
    input logic berr_out,
    input logic tok_out,
    input logic irq,
    input logic st_tok,
    input logic st_berr
);
    // R1: no answer of any kind without a host read
    assert_answer_needs_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_en || berr_out) |-> bus_rd);

    // R3: hand-off pulse lasts one cycle and the token is gone with it
    assert_tok_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out);
    assert_tok_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> !st_tok);

    // R4: an incoming token is owned after the edge
    assert_tok_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !st_tok) |=> st_tok);

    // R5: data and bus error are never given together
    assert_berr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_en && berr_out));

    // R7: the first board reclaims the token on a bus error
    assert_reclaim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_in && cfg_mb_en && cfg_first) |=> st_tok);

    // R8: own bus error leaves the sticky status set
    assert_berr_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        berr_out |=> st_berr);

    // R10: interrupt is a single-cycle pulse
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind mblk_rd_ctrl mblk_rd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mb_en (cfg_mb_en),
    .cfg_first (cfg_first),
    .bus_rd    (bus_rd),
    .tok_in    (tok_in),
    .berr_in   (berr_in),
    .resp_en   (resp_en),
    .berr_out  (berr_out),
    .tok_out   (tok_out),
    .irq       (irq),
    .st_tok    (st_tok),
    .st_berr   (st_berr)
);

// File: tb/tb_mblk_rd_ctrl.sv
module tb_mblk_rd_ctrl;
    localparam int AW = 24;
    localparam int OB = 8;
    localparam int CW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mb_en = 1'b0, cfg_first = 1'b0, cfg_last = 1'b0;
    logic cfg_berr_en = 1'b0, cfg_irq_en = 1'b0, cfg_own_en = 1'b0;
    logic [AW-OB-1:0] cfg_own_page = 16'h0030;
    logic [AW-1:0] cfg_win_lo = 24'h000100;
    logic [AW-1:0] cfg_win_hi = 24'h000200;
    logic [CW-1:0] cfg_quota = 16'd2;
    logic [AW-1:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic evt_stored = 1'b0, evt_last = 1'b0, tok_in = 1'b0, berr_in = 1'b0, stat_rd = 1'b0;
    logic resp_en, berr_out, tok_out, irq, st_tok, st_berr, st_level;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mblk_rd_ctrl #(.AW(AW), .OB(OB), .CW(CW), .DW(DW)) dut (.*);

    // address, read strobe, expected resp_en (shared window 0x100..0x1FF, private page 0x30)
    localparam logic [AW+1:0] VEC [7] = '{
        {24'h0000FF, 1'b1, 1'b0},
        {24'h000100, 1'b1, 1'b1},
        {24'h0001FF, 1'b1, 1'b1},
        {24'h000200, 1'b1, 1'b0},
        {24'h003005, 1'b1, 1'b1},
        {24'h003105, 1'b1, 1'b0},
        {24'h000150, 1'b0, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_rd = 0; bus_wr = 0; evt_stored = 0; evt_last = 0;
        tok_in = 0; berr_in = 0; stat_rd = 0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // ---- first board in chain, not last ----
        cfg_mb_en = 1; cfg_first = 1; cfg_own_en = 1; cfg_quota = 2;
        do_reset();
        #1;
        chk("R12 st_tok in reset window", st_tok, 0);
        chk("R12 tok_out", tok_out, 0);
        chk("R12 irq", irq, 0);
        chk("R12 st_berr", st_berr, 0);
        chk("R12 st_level", st_level, 0);
        step();
        chk("R2 first board claims token", st_tok, 1);

        for (int i = 0; i < 7; i++) begin
            bus_addr = VEC[i][AW+1:2];
            bus_rd   = VEC[i][1];
            #1;
            chk($sformatf("R1 decode vector %0d", i), resp_en, VEC[i][0]);
            chk($sformatf("R1 no berr vector %0d", i), berr_out, 0);
        end

        // R3: hand-off after the quota
        bus_addr = 24'h000150; bus_rd = 1; evt_last = 1;
        step();
        chk("R3 no pulse before quota", tok_out, 0);
        chk("R3 token kept before quota", st_tok, 1);
        step();
        evt_last = 0;
        chk("R3 tok_out pulse", tok_out, 1);
        chk("R3 token released", st_tok, 0);
        #1;
        chk("R1 no answer without token", resp_en, 0);
        bus_rd = 0;
        step();
        chk("R3 pulse one cycle", tok_out, 0);

        // R4: incoming token
        tok_in = 1;
        #1;
        chk("R4 not owned before edge", st_tok, 0);
        step();
        tok_in = 0;
        chk("R4 owned after edge", st_tok, 1);

        // R7: give it away again, reclaim on bus error
        bus_rd = 1; evt_last = 1;
        step();
        step();
        bus_rd = 0; evt_last = 0;
        chk("R3 second hand-off", st_tok, 0);
        berr_in = 1;
        step();
        berr_in = 0;
        chk("R7 first board reclaims", st_tok, 1);

        // ---- middle board: no claim, no reclaim ----
        cfg_first = 0;
        do_reset();
        step();
        chk("R2 non-first starts without token", st_tok, 0);
        berr_in = 1;
        step();
        berr_in = 0;
        chk("R7 non-first ignores bus error for token", st_tok, 0);
        bus_addr = 24'h000150; bus_rd = 1;
        #1;
        chk("R1 middle board silent", resp_en, 0);
        bus_rd = 0;

        // ---- single-member chain: first and last ----
        cfg_first = 1; cfg_last = 1; cfg_berr_en = 1; cfg_quota = 0;
        do_reset();
        step();
        bus_addr = 24'h000150; bus_rd = 1; evt_last = 1;
        #1;
        chk("R1 last board answers", resp_en, 1);
        step();
        evt_last = 0;
        chk("R5 last keeps token (quota 0 acts as 1)", st_tok, 1);
        chk("R5 last sends no pulse", tok_out, 0);
        #1;
        chk("R5 berr after block", berr_out, 1);
        chk("R5 no data after block", resp_en, 0);
        step();
        bus_rd = 0;
        chk("R8 status set", st_berr, 1);
        step();
        chk("R8 status sticky", st_berr, 1);
        stat_rd = 1;
        step();
        stat_rd = 0;
        chk("R8 status cleared by read", st_berr, 0);
        berr_in = 1;
        step();
        berr_in = 0;
        bus_rd = 1;
        #1;
        chk("R7 progress cleared", resp_en, 1);
        chk("R7 no berr after clear", berr_out, 0);
        bus_rd = 0;

        // ---- single board with interrupt ----
        cfg_mb_en = 0; cfg_first = 0; cfg_last = 0; cfg_quota = 2; cfg_irq_en = 1;
        do_reset();
        step();
        chk("R2 single board holds no token", st_tok, 0);
        bus_addr = 24'h000150; bus_rd = 1;
        #1;
        chk("R1 shared window off when multiblock disabled", resp_en, 0);
        bus_rd = 0;
        evt_stored = 1;
        step();
        chk("R9 level below quota", st_level, 0);
        step();
        evt_stored = 0;
        chk("R9 level at quota", st_level, 1);
        chk("R10 irq not yet", irq, 0);
        step();
        chk("R10 irq pulse", irq, 1);
        step();
        chk("R10 irq ends", irq, 0);
        bus_addr = 24'h003004; bus_wr = 1; bus_wdata = 32'h8000_0001;
        step();
        bus_wr = 0;
        step();
        chk("R11 bad rearm ignored", irq, 0);
        step();
        chk("R11 bad rearm ignored later", irq, 0);
        bus_wr = 1; bus_wdata = 32'h8000_0000;
        step();
        bus_wr = 0;
        step();
        chk("R11 rearm fires irq", irq, 1);

        bus_addr = 24'h003008; bus_rd = 1; evt_last = 1;
        step();
        step();
        evt_last = 0;
        chk("R9 level drops after reads", st_level, 0);
        #1;
        chk("R6 single berr", berr_out, 1);
        chk("R6 single no data", resp_en, 0);
        step();
        chk("R8 single status", st_berr, 1);
        cfg_berr_en = 0;
        #1;
        chk("R6 no berr when disabled", berr_out, 0);
        chk("R6 no data when disabled", resp_en, 0);
        bus_rd = 0;

        // ---- middle board may not interrupt ----
        cfg_mb_en = 1; cfg_first = 0; cfg_quota = 1; cfg_irq_en = 1;
        do_reset();
        evt_stored = 1;
        step();
        evt_stored = 0;
        chk("R9 middle level", st_level, 1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk($sformatf("R10 middle board no irq %0d", k), irq, 0);
        end

        finish_run();
    end
endmodule